// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the architectural state changes a processor makes when it enters an exception handler. A pipeline presents a synchronous request with the faulting program counter, a cause code and, when relevant, a faulting virtual address. A debug request with its own cause code may arrive in the same cycle. The block owns the processor status word (exception-mode bit, user-mode bit, interrupt-level field) and the save registers: one saved PC per interrupt level, an optional double-exception PC, one saved status word per level from two upward, the cause register, the debug cause register and the faulting-address register.

For each accepted entry, the block picks one of four handler kinds from the status bits: kernel, user, double or debug. It produces a one-cycle redirect strobe and the handler address. The address may be re-based at run time from a build-time vector base to a programmable vector-base register. The pipeline may also write the status word and the vector base directly, for example on handler return. A vector parameter of zero marks a handler kind that is missing. Such an entry updates the state but raises an error pulse instead of a redirect.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word is zero, every save register is zero, the vector-base register holds STATIC_VECBASE, and redirect and bad_vector are low.
- R2: A general request taken with the exception-mode bit clear stores the PC into the level-1 saved PC (epc_flat bits 31:0) and selects VEC_USER when the user-mode bit is set, otherwise VEC_KERNEL.
- R3: A general request taken with the exception-mode bit set selects VEC_DOUBLE. It stores the PC into depc_q when HAS_DEPC is 1 (level-1 saved PC untouched), otherwise into the level-1 saved PC.
- R4: Every general entry writes exc_cause into cause_q and sets the exception-mode bit, leaving the user-mode bit and the level field unchanged.
- R5: A general entry with exc_vaddr_vld high writes exc_vaddr into vaddr_q; in every other cycle vaddr_q holds.
- R6: The effective level is the level field when the exception-mode bit is clear. When that bit is set, it is the larger of the level field and EXCM_LEVEL.
- R7: A debug request is accepted when the effective level is below DEBUG_LEVEL (D). It then writes dbg_cause into dcause_q, the PC into the level-D saved PC (epc_flat slice D-1) and the old status word into the level-D saved status (eps_flat slice D-2). It sets the exception-mode bit, sets the level field to D, keeps the user-mode bit and selects VEC_DEBUG. An accepted debug request takes priority over a general request in the same cycle.
- R8: A debug request that is not accepted changes no state and produces no redirect. A general request in the same cycle proceeds as if it were alone.
- R9: With RELOC_EN=1 the handler address is the selected vector minus STATIC_VECBASE plus the vector-base register as it stood before the entry edge. With RELOC_EN=0 it is the selected vector unchanged.
- R10: When the selected vector is zero, the entry still updates all state. redirect stays low, and bad_vector pulses high for one cycle.
- R11: redirect and redirect_pc become valid at the clock edge that samples the request and last one cycle. redirect_pc is zero whenever redirect is low. The status and save registers update on that same edge.
- R12: ps_wr_en loads ps_wr_data into the status word only in cycles with no entry; an entry in the same cycle drops the write. The status word is packed as {user-mode bit 5, exception-mode bit 4, level 3:0}. vb_wr_en loads the vector-base register in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | Cause code of the general request |
| exc_pc | input | XLEN | Faulting program counter |
| exc_vaddr_vld | input | 1 | Request carries a faulting virtual address |
| exc_vaddr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| ps_wr_en | input | 1 | Status word write enable |
| ps_wr_data | input | LVL_W+2 | Status word write value |
| vb_wr_en | input | 1 | Vector-base write enable |
| vb_wr_data | input | XLEN | Vector-base write value |
| redirect | output | 1 | One-cycle handler redirect strobe |
| redirect_pc | output | XLEN | Handler address, zero without redirect |
| bad_vector | output | 1 | One-cycle missing-vector error |
| status_um | output | 1 | User-mode bit |
| status_excm | output | 1 | Exception-mode bit |
| status_lvl | output | LVL_W | Interrupt-level field |
| epc_flat | output | NUM_LEVELS*XLEN | Saved PC per level, level L at slice L-1 |
| depc_q | output | XLEN | Double-exception saved PC |
| eps_flat | output | (NUM_LEVELS-1)*(LVL_W+2) | Saved status per level, level L at slice L-2 |
| cause_q | output | CAUSE_W | Cause register |
| dcause_q | output | DCAUSE_W | Debug cause register |
| vaddr_q | output | XLEN | Faulting-address register |
| vecbase_q | output | XLEN | Programmable vector base |

## Verification
Every result of this block is due at the first rising edge after a request is presented. That covers the redirect strobe, the handler address, the error pulse and every status and save register. A result that is still visible one cycle later is a fault. The bench drives inputs on the falling edge, steps its model once per drive, and compares every output port on the next falling edge. This catches results that are late, early or held too long. Two instances run side by side: one with a double-exception register and relocation, one without either and with a missing user vector. Both instances receive the same directed and random stimulus.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
   localparam int LVL_W = 4;
   localparam int PS_W  = LVL_W + 2;

   typedef struct packed {
      logic             um;
      logic             excm;
      logic [LVL_W-1:0] lvl;
   } exc_status_t;

   typedef enum logic [2:0] {
      KIND_NONE,
      KIND_KERNEL,
      KIND_USER,
      KIND_DOUBLE,
      KIND_DEBUG
   } exc_kind_e;

   function automatic logic is_general(exc_kind_e k);
      return (k == KIND_KERNEL) || (k == KIND_USER) || (k == KIND_DOUBLE);
   endfunction
endpackage

// File: rtl/exc_kind_sel.sv
`timescale 1ns/1ps
module exc_kind_sel
   import exc_entry_pkg::*;
#(
   parameter int DEBUG_LEVEL = 4,
   parameter int EXCM_LEVEL  = 1
) (
   input  exc_status_t      st,
   input  logic             exc_req,
   input  logic             dbg_req,
   output exc_kind_e        kind,
   output logic [LVL_W-1:0] eff_lvl
);
   localparam logic [LVL_W-1:0] XLVL = LVL_W'(EXCM_LEVEL);
   localparam logic [LVL_W-1:0] DLVL = LVL_W'(DEBUG_LEVEL);

   logic dbg_take;

   always_comb begin
      if (st.excm && (st.lvl < XLVL)) eff_lvl = XLVL;
      else                            eff_lvl = st.lvl;
   end

   assign dbg_take = dbg_req && (eff_lvl < DLVL);

   always_comb begin
      kind = KIND_NONE;
      if (dbg_take)           kind = KIND_DEBUG;
      else if (exc_req) begin
         if (st.excm)         kind = KIND_DOUBLE;
         else if (st.um)      kind = KIND_USER;
         else                 kind = KIND_KERNEL;
      end
   end
endmodule

// File: rtl/exc_vec_map.sv
`timescale 1ns/1ps
module exc_vec_map
   import exc_entry_pkg::*;
#(
   parameter int              XLEN           = 32,
   parameter bit              RELOC_EN       = 1'b1,
   parameter logic [XLEN-1:0] STATIC_VECBASE = '0,
   parameter logic [XLEN-1:0] VEC_KERNEL     = '0,
   parameter logic [XLEN-1:0] VEC_USER       = '0,
   parameter logic [XLEN-1:0] VEC_DOUBLE     = '0,
   parameter logic [XLEN-1:0] VEC_DEBUG      = '0
) (
   input  exc_kind_e        kind,
   input  logic [XLEN-1:0]  vecbase,
   output logic [XLEN-1:0]  target,
   output logic             missing
);
   logic [XLEN-1:0] raw;

   always_comb begin
      unique case (kind)
         KIND_KERNEL: raw = VEC_KERNEL;
         KIND_USER:   raw = VEC_USER;
         KIND_DOUBLE: raw = VEC_DOUBLE;
         KIND_DEBUG:  raw = VEC_DEBUG;
         default:     raw = '0;
      endcase
   end

   assign missing = (kind != KIND_NONE) && (raw == '0);

   generate
      if (RELOC_EN) begin : g_reloc
         assign target = raw - STATIC_VECBASE + vecbase;
      end else begin : g_static
         assign target = raw;
      end
   endgenerate
endmodule

// File: rtl/exc_save_regs.sv
`timescale 1ns/1ps
module exc_save_regs
   import exc_entry_pkg::*;
#(
   parameter int              XLEN           = 32,
   parameter int              CAUSE_W        = 6,
   parameter int              DCAUSE_W       = 6,
   parameter int              NUM_LEVELS     = 6,
   parameter int              DEBUG_LEVEL    = 4,
   parameter bit              HAS_DEPC       = 1'b1,
   parameter logic [XLEN-1:0] STATIC_VECBASE = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  exc_kind_e                    kind,
   input  logic [XLEN-1:0]              exc_pc,
   input  logic [CAUSE_W-1:0]           exc_cause,
   input  logic                         exc_vaddr_vld,
   input  logic [XLEN-1:0]              exc_vaddr,
   input  logic [DCAUSE_W-1:0]          dbg_cause,
   input  logic                         ps_wr_en,
   input  exc_status_t                  ps_wr_data,
   input  logic                         vb_wr_en,
   input  logic [XLEN-1:0]              vb_wr_data,
   output exc_status_t                  st_q,
   output logic [NUM_LEVELS*XLEN-1:0]   epc_flat,
   output logic [XLEN-1:0]              depc_q,
   output logic [(NUM_LEVELS-1)*PS_W-1:0] eps_flat,
   output logic [CAUSE_W-1:0]           cause_q,
   output logic [DCAUSE_W-1:0]          dcause_q,
   output logic [XLEN-1:0]              vaddr_q,
   output logic [XLEN-1:0]              vecbase_q
);
   localparam logic [LVL_W-1:0] DLVL = LVL_W'(DEBUG_LEVEL);

   logic        gen_entry;
   logic        dbg_entry;
   logic        lvl1_pc_wr;
   exc_status_t st_d;

   assign gen_entry  = is_general(kind);
   assign dbg_entry  = (kind == KIND_DEBUG);
   assign lvl1_pc_wr = (kind == KIND_KERNEL) || (kind == KIND_USER) ||
                       ((kind == KIND_DOUBLE) && !HAS_DEPC);

   // status word next state: entries win over direct writes
   always_comb begin
      st_d = st_q;
      if (dbg_entry) begin
         st_d.excm = 1'b1;
         st_d.lvl  = DLVL;
      end else if (gen_entry) begin
         st_d.excm = 1'b1;
      end else if (ps_wr_en) begin
         st_d = ps_wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   // saved PC per level
   generate
      for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_epc
         logic [XLEN-1:0] q;
         logic            wr;
         assign wr = ((l == 1) && lvl1_pc_wr) || ((l == DEBUG_LEVEL) && dbg_entry);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (wr) q <= exc_pc;
         end
         assign epc_flat[(l-1)*XLEN +: XLEN] = q;
      end

      // saved status per level from two upward
      for (genvar l = 2; l <= NUM_LEVELS; l++) begin : g_eps
         exc_status_t q;
         logic        wr;
         assign wr = (l == DEBUG_LEVEL) && dbg_entry;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (wr) q <= st_q;
         end
         assign eps_flat[(l-2)*PS_W +: PS_W] = q;
      end

      if (HAS_DEPC) begin : g_depc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         depc_q <= '0;
            else if (kind == KIND_DOUBLE)       depc_q <= exc_pc;
         end
      end else begin : g_no_depc
         assign depc_q = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q   <= '0;
         dcause_q  <= '0;
         vaddr_q   <= '0;
         vecbase_q <= STATIC_VECBASE;
      end else begin
         if (gen_entry)                  cause_q  <= exc_cause;
         if (dbg_entry)                  dcause_q <= dbg_cause;
         if (gen_entry && exc_vaddr_vld) vaddr_q  <= exc_vaddr;
         if (vb_wr_en)                   vecbase_q <= vb_wr_data;
      end
   end
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int              XLEN           = 32,
   parameter int              CAUSE_W        = 6,
   parameter int              DCAUSE_W       = 6,
   parameter int              NUM_LEVELS     = 6,
   parameter int              DEBUG_LEVEL    = 4,
   parameter int              EXCM_LEVEL     = 1,
   parameter bit              HAS_DEPC       = 1'b1,
   parameter bit              RELOC_EN       = 1'b1,
   parameter logic [XLEN-1:0] STATIC_VECBASE = 32'h4000_0000,
   parameter logic [XLEN-1:0] VEC_KERNEL     = 32'h4000_0300,
   parameter logic [XLEN-1:0] VEC_USER       = 32'h4000_0340,
   parameter logic [XLEN-1:0] VEC_DOUBLE     = 32'h4000_03C0,
   parameter logic [XLEN-1:0] VEC_DEBUG      = 32'h4000_0280
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                exc_req,
   input  logic [CAUSE_W-1:0]                  exc_cause,
   input  logic [XLEN-1:0]                     exc_pc,
   input  logic                                exc_vaddr_vld,
   input  logic [XLEN-1:0]                     exc_vaddr,
   input  logic                                dbg_req,
   input  logic [DCAUSE_W-1:0]                 dbg_cause,
   input  logic                                ps_wr_en,
   input  logic [LVL_W+1:0]                    ps_wr_data,
   input  logic                                vb_wr_en,
   input  logic [XLEN-1:0]                     vb_wr_data,
   output logic                                redirect,
   output logic [XLEN-1:0]                     redirect_pc,
   output logic                                bad_vector,
   output logic                                status_um,
   output logic                                status_excm,
   output logic [LVL_W-1:0]                    status_lvl,
   output logic [NUM_LEVELS*XLEN-1:0]          epc_flat,
   output logic [XLEN-1:0]                     depc_q,
   output logic [(NUM_LEVELS-1)*(LVL_W+2)-1:0] eps_flat,
   output logic [CAUSE_W-1:0]                  cause_q,
   output logic [DCAUSE_W-1:0]                 dcause_q,
   output logic [XLEN-1:0]                     vaddr_q,
   output logic [XLEN-1:0]                     vecbase_q
);
   localparam int MAX_LVL = (1 << LVL_W) - 1;

   // elaboration-time parameter checks
   generate
      if (NUM_LEVELS < 2 || NUM_LEVELS > MAX_LVL) begin : g_chk_levels
         $error("exc_entry_seq: NUM_LEVELS out of range");
      end
      if (DEBUG_LEVEL < 2 || DEBUG_LEVEL > NUM_LEVELS) begin : g_chk_dbg
         $error("exc_entry_seq: DEBUG_LEVEL must lie in 2..NUM_LEVELS");
      end
      if (EXCM_LEVEL < 1 || EXCM_LEVEL > NUM_LEVELS) begin : g_chk_excm
         $error("exc_entry_seq: EXCM_LEVEL must lie in 1..NUM_LEVELS");
      end
      if (XLEN < 8 || CAUSE_W < 1 || DCAUSE_W < 1) begin : g_chk_width
         $error("exc_entry_seq: width parameters too small");
      end
   endgenerate

   exc_status_t      st;
   exc_kind_e        kind;
   logic [LVL_W-1:0] eff_lvl;
   logic [XLEN-1:0]  target;
   logic             missing;
   logic             go;

   exc_kind_sel #(
      .DEBUG_LEVEL (DEBUG_LEVEL),
      .EXCM_LEVEL  (EXCM_LEVEL)
   ) u_kind (
      .st      (st),
      .exc_req (exc_req),
      .dbg_req (dbg_req),
      .kind    (kind),
      .eff_lvl (eff_lvl)
   );

   exc_vec_map #(
      .XLEN           (XLEN),
      .RELOC_EN       (RELOC_EN),
      .STATIC_VECBASE (STATIC_VECBASE),
      .VEC_KERNEL     (VEC_KERNEL),
      .VEC_USER       (VEC_USER),
      .VEC_DOUBLE     (VEC_DOUBLE),
      .VEC_DEBUG      (VEC_DEBUG)
   ) u_map (
      .kind    (kind),
      .vecbase (vecbase_q),
      .target  (target),
      .missing (missing)
   );

   exc_save_regs #(
      .XLEN           (XLEN),
      .CAUSE_W        (CAUSE_W),
      .DCAUSE_W       (DCAUSE_W),
      .NUM_LEVELS     (NUM_LEVELS),
      .DEBUG_LEVEL    (DEBUG_LEVEL),
      .HAS_DEPC       (HAS_DEPC),
      .STATIC_VECBASE (STATIC_VECBASE)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .kind          (kind),
      .exc_pc        (exc_pc),
      .exc_cause     (exc_cause),
      .exc_vaddr_vld (exc_vaddr_vld),
      .exc_vaddr     (exc_vaddr),
      .dbg_cause     (dbg_cause),
      .ps_wr_en      (ps_wr_en),
      .ps_wr_data    (exc_status_t'(ps_wr_data)),
      .vb_wr_en      (vb_wr_en),
      .vb_wr_data    (vb_wr_data),
      .st_q          (st),
      .epc_flat      (epc_flat),
      .depc_q        (depc_q),
      .eps_flat      (eps_flat),
      .cause_q       (cause_q),
      .dcause_q      (dcause_q),
      .vaddr_q       (vaddr_q),
      .vecbase_q     (vecbase_q)
   );

   assign go = (kind != KIND_NONE) && !missing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect    <= 1'b0;
         redirect_pc <= '0;
         bad_vector  <= 1'b0;
      end else begin
         redirect    <= go;
         redirect_pc <= go ? target : '0;
         bad_vector  <= (kind != KIND_NONE) && missing;
      end
   end

   assign status_um   = st.um;
   assign status_excm = st.excm;
   assign status_lvl  = st.lvl;
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
   import exc_entry_pkg::*;
#(
   parameter int CAUSE_W     = 6,
   parameter int DCAUSE_W    = 6,
   parameter int XLEN        = 32,
   parameter int DEBUG_LEVEL = 4,
   parameter int EXCM_LEVEL  = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                exc_req,
   input logic [CAUSE_W-1:0]  exc_cause,
   input logic                dbg_req,
   input logic [DCAUSE_W-1:0] dbg_cause,
   input logic                ps_wr_en,
   input logic [LVL_W+1:0]    ps_wr_data,
   input logic                redirect,
   input logic                bad_vector,
   input logic                status_um,
   input logic                status_excm,
   input logic [LVL_W-1:0]    status_lvl,
   input logic [CAUSE_W-1:0]  cause_q,
   input logic [DCAUSE_W-1:0] dcause_q,
   input logic [XLEN-1:0]     vaddr_q
);
   int eff;
   assign eff = (status_excm && (int'(status_lvl) < EXCM_LEVEL)) ? EXCM_LEVEL
                                                                : int'(status_lvl);

   assert_gen_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !dbg_req) |=> (status_excm && cause_q == $past(exc_cause) &&
                                 status_lvl == $past(status_lvl) &&
                                 status_um == $past(status_um)));

   assert_vaddr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |=> (vaddr_q == $past(vaddr_q)));

   assert_dbg_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && eff < DEBUG_LEVEL) |=> (status_excm &&
         int'(status_lvl) == DEBUG_LEVEL && dcause_q == $past(dbg_cause)));

   assert_dbg_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && !exc_req && eff >= DEBUG_LEVEL) |=>
         (!redirect && !bad_vector && dcause_q == $past(dcause_q)));

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(redirect && bad_vector));

   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && !dbg_req) |=> (!redirect && !bad_vector));

   assert_ps_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_wr_en && !exc_req && !dbg_req) |=>
         ({status_um, status_excm, status_lvl} == $past(ps_wr_data)));
endmodule

bind exc_entry_seq exc_entry_chk #(
   .CAUSE_W     (CAUSE_W),
   .DCAUSE_W    (DCAUSE_W),
   .XLEN        (XLEN),
   .DEBUG_LEVEL (DEBUG_LEVEL),
   .EXCM_LEVEL  (EXCM_LEVEL)
) u_exc_entry_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exc_req     (exc_req),
   .exc_cause   (exc_cause),
   .dbg_req     (dbg_req),
   .dbg_cause   (dbg_cause),
   .ps_wr_en    (ps_wr_en),
   .ps_wr_data  (ps_wr_data),
   .redirect    (redirect),
   .bad_vector  (bad_vector),
   .status_um   (status_um),
   .status_excm (status_excm),
   .status_lvl  (status_lvl),
   .cause_q     (cause_q),
   .dcause_q    (dcause_q),
   .vaddr_q     (vaddr_q)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
   localparam logic [31:0] V_BASE = 32'h4000_0000;
   localparam logic [31:0] V_KER  = 32'h4000_0300;
   localparam logic [31:0] V_USR  = 32'h4000_0340;
   localparam logic [31:0] V_DBL  = 32'h4000_03C0;
   localparam logic [31:0] V_DBG  = 32'h4000_0280;
   localparam int          DBG_L  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        exc_req = 0, exc_vaddr_vld = 0, dbg_req = 0, ps_wr_en = 0, vb_wr_en = 0;
   logic [5:0]  exc_cause = 0, dbg_cause = 0, ps_wr_data = 0;
   logic [31:0] exc_pc = 0, exc_vaddr = 0, vb_wr_data = 0;

   logic        o_redir [2];
   logic        o_bad   [2];
   logic [31:0] o_rpc   [2];
   logic        o_um    [2];
   logic        o_excm  [2];
   logic [3:0]  o_lvl   [2];
   logic [191:0] o_epc  [2];
   logic [31:0] o_depc  [2];
   logic [29:0] o_eps   [2];
   logic [5:0]  o_cause [2];
   logic [5:0]  o_dcause[2];
   logic [31:0] o_vaddr [2];
   logic [31:0] o_vb    [2];

   exc_entry_seq #(
      .HAS_DEPC(1'b1), .RELOC_EN(1'b1), .STATIC_VECBASE(V_BASE),
      .VEC_KERNEL(V_KER), .VEC_USER(V_USR), .VEC_DOUBLE(V_DBL), .VEC_DEBUG(V_DBG),
      .DEBUG_LEVEL(DBG_L)
   ) i_exc_entry_seq (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
      .exc_pc(exc_pc), .exc_vaddr_vld(exc_vaddr_vld), .exc_vaddr(exc_vaddr),
      .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_wr_en(ps_wr_en),
      .ps_wr_data(ps_wr_data), .vb_wr_en(vb_wr_en), .vb_wr_data(vb_wr_data),
      .redirect(o_redir[0]), .redirect_pc(o_rpc[0]), .bad_vector(o_bad[0]),
      .status_um(o_um[0]), .status_excm(o_excm[0]), .status_lvl(o_lvl[0]),
      .epc_flat(o_epc[0]), .depc_q(o_depc[0]), .eps_flat(o_eps[0]),
      .cause_q(o_cause[0]), .dcause_q(o_dcause[0]), .vaddr_q(o_vaddr[0]),
      .vecbase_q(o_vb[0])
   );

   exc_entry_seq #(
      .HAS_DEPC(1'b0), .RELOC_EN(1'b0), .STATIC_VECBASE(V_BASE),
      .VEC_KERNEL(V_KER), .VEC_USER(32'h0), .VEC_DOUBLE(V_DBL), .VEC_DEBUG(V_DBG),
      .DEBUG_LEVEL(DBG_L)
   ) i_exc_entry_seq_b (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
      .exc_pc(exc_pc), .exc_vaddr_vld(exc_vaddr_vld), .exc_vaddr(exc_vaddr),
      .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_wr_en(ps_wr_en),
      .ps_wr_data(ps_wr_data), .vb_wr_en(vb_wr_en), .vb_wr_data(vb_wr_data),
      .redirect(o_redir[1]), .redirect_pc(o_rpc[1]), .bad_vector(o_bad[1]),
      .status_um(o_um[1]), .status_excm(o_excm[1]), .status_lvl(o_lvl[1]),
      .epc_flat(o_epc[1]), .depc_q(o_depc[1]), .eps_flat(o_eps[1]),
      .cause_q(o_cause[1]), .dcause_q(o_dcause[1]), .vaddr_q(o_vaddr[1]),
      .vecbase_q(o_vb[1])
   );

   // bench model, one per instance (0: depc+reloc, 1: neither, no user vector)
   logic [31:0] m_epc   [2][1:6];
   logic [5:0]  m_eps   [2][2:6];
   logic [5:0]  m_ps    [2];
   logic [31:0] m_depc  [2];
   logic [5:0]  m_cause [2];
   logic [5:0]  m_dcause[2];
   logic [31:0] m_vaddr [2];
   logic [31:0] m_vb    [2];
   logic        m_redir [2];
   logic        m_bad   [2];
   logic [31:0] m_rpc   [2];

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input int k, input logic [191:0] act,
                      input logic [191:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s inst%0d actual=%h expected=%h", tag, k, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         for (int l = 1; l <= 6; l++) m_epc[k][l] = '0;
         for (int l = 2; l <= 6; l++) m_eps[k][l] = '0;
         m_ps[k] = '0; m_depc[k] = '0; m_cause[k] = '0; m_dcause[k] = '0;
         m_vaddr[k] = '0; m_vb[k] = V_BASE;
         m_redir[k] = 1'b0; m_bad[k] = 1'b0; m_rpc[k] = '0;
      end
   endtask

   task automatic model_step(input int k);
      logic [3:0]  lvl;
      logic        excm, um, entry;
      logic [3:0]  eff;
      logic [31:0] vec;
      lvl = m_ps[k][3:0]; excm = m_ps[k][4]; um = m_ps[k][5];
      eff = (excm && lvl == 4'd0) ? 4'd1 : lvl;   // R6 with EXCM_LEVEL 1
      entry = 1'b0; vec = '0;
      if (dbg_req && eff < 4'(DBG_L)) begin
         m_dcause[k] = dbg_cause;
         m_epc[k][DBG_L] = exc_pc;
         m_eps[k][DBG_L] = m_ps[k];
         m_ps[k][4] = 1'b1;
         m_ps[k][3:0] = 4'(DBG_L);
         vec = V_DBG; entry = 1'b1;
      end else if (exc_req) begin
         if (exc_vaddr_vld) m_vaddr[k] = exc_vaddr;
         if (excm) begin
            if (k == 0) m_depc[k] = exc_pc;
            else        m_epc[k][1] = exc_pc;
            vec = V_DBL;
         end else begin
            m_epc[k][1] = exc_pc;
            vec = um ? ((k == 0) ? V_USR : 32'h0) : V_KER;
         end
         m_cause[k] = exc_cause;
         m_ps[k][4] = 1'b1;
         entry = 1'b1;
      end else if (ps_wr_en) begin
         m_ps[k] = ps_wr_data;
      end
      m_redir[k] = entry && (vec != 0);
      m_bad[k]   = entry && (vec == 0);
      m_rpc[k]   = !m_redir[k] ? 32'h0 : ((k == 0) ? vec - V_BASE + m_vb[k] : vec);
      if (vb_wr_en) m_vb[k] = vb_wr_data;
   endtask

   task automatic check_all(input string pfx);
      for (int k = 0; k < 2; k++) begin
         logic [191:0] ef;
         logic [29:0]  sf;
         for (int l = 1; l <= 6; l++) ef[(l-1)*32 +: 32] = m_epc[k][l];
         for (int l = 2; l <= 6; l++) sf[(l-2)*6 +: 6] = m_eps[k][l];
         chk({pfx, " R8 R11 redirect"}, k, 192'(o_redir[k]), 192'(m_redir[k]));
         chk({pfx, " R9 R11 redirect_pc"}, k, 192'(o_rpc[k]), 192'(m_rpc[k]));
         chk({pfx, " R10 bad_vector"}, k, 192'(o_bad[k]), 192'(m_bad[k]));
         chk({pfx, " R4 R6 R7 R12 status"}, k,
             192'({o_um[k], o_excm[k], o_lvl[k]}), 192'(m_ps[k]));
         chk({pfx, " R2 R3 R7 epc"}, k, o_epc[k], ef);
         chk({pfx, " R3 depc"}, k, 192'(o_depc[k]), 192'(m_depc[k]));
         chk({pfx, " R7 eps"}, k, 192'(o_eps[k]), 192'(sf));
         chk({pfx, " R4 cause"}, k, 192'(o_cause[k]), 192'(m_cause[k]));
         chk({pfx, " R7 dcause"}, k, 192'(o_dcause[k]), 192'(m_dcause[k]));
         chk({pfx, " R5 vaddr"}, k, 192'(o_vaddr[k]), 192'(m_vaddr[k]));
         chk({pfx, " R12 vecbase"}, k, 192'(o_vb[k]), 192'(m_vb[k]));
      end
   endtask

   task automatic drive(input logic e, input logic [5:0] c, input logic [31:0] pc,
                        input logic vv, input logic [31:0] va, input logic d,
                        input logic [5:0] dc, input logic pw, input logic [5:0] pd,
                        input logic vw, input logic [31:0] vd, input string tag);
      exc_req = e; exc_cause = c; exc_pc = pc; exc_vaddr_vld = vv; exc_vaddr = va;
      dbg_req = d; dbg_cause = dc; ps_wr_en = pw; ps_wr_data = pd;
      vb_wr_en = vw; vb_wr_data = vd;
      model_step(0);
      model_step(1);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired R11 actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      // directed corner cases
      drive(1, 6'h03, 32'h1000, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, "R2 kernel");
      drive(1, 6'h05, 32'h1004, 0, 0, 0, 0, 0, 0, 0, 0, "R3 double");
      drive(0, 0, 0, 0, 0, 0, 0, 1, 6'b10_0000, 0, 0, "R12 ps write user");
      drive(1, 6'h07, 32'h2000, 0, 0, 0, 0, 0, 0, 0, 0, "R10 user/missing");
      drive(0, 0, 0, 0, 0, 0, 0, 1, 6'b00_0011, 0, 0, "R12 level 3");
      drive(0, 0, 32'h3000, 0, 0, 1, 6'h11, 0, 0, 0, 0, "R7 debug taken");
      drive(0, 0, 32'h3004, 0, 0, 1, 6'h12, 0, 0, 0, 0, "R8 debug ignored");
      drive(0, 0, 0, 0, 0, 0, 0, 1, 6'b01_0000, 1, 32'h8000_0000, "R12 vb write");
      drive(1, 6'h09, 32'h4000, 1, 32'h55, 1, 6'h13, 0, 0, 0, 0, "R6 R7 debug wins");
      drive(1, 6'h0A, 32'h4004, 0, 0, 1, 6'h14, 0, 0, 0, 0, "R8 debug drop, general");
      drive(1, 6'h0B, 32'h4008, 0, 0, 0, 0, 1, 6'b00_0000, 0, 0, "R12 write dropped");
      drive(0, 0, 0, 0, 0, 0, 0, 1, 6'b00_0000, 0, 0, "R12 clear status");
      drive(1, 6'h0C, 32'h5000, 0, 0, 0, 0, 0, 0, 0, 0, "R9 kernel relocated");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");

      // constrained random phase
      for (int n = 0; n < 800; n++) begin
         logic e, d, pw, vw, vv;
         logic [5:0] pd;
         e  = ($urandom_range(0, 9) < 4);
         d  = ($urandom_range(0, 9) < 2);
         pw = ($urandom_range(0, 9) < 3);
         vw = ($urandom_range(0, 9) < 1);
         vv = $urandom_range(0, 1) == 1;
         pd = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               4'($urandom_range(0, 6))};
         drive(e, 6'($urandom), $urandom, vv, $urandom, d, 6'($urandom),
               pw, pd, vw, {$urandom_range(0, 15) == 0 ? 4'h4 : 4'($urandom), 28'h0},
               "random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule